// File: doc/BRIEF.md
# Vector Lane Conflict Detector

This unit looks at a packed vector of up to 512 bits, split into 32-bit or 64-bit lanes, and reports for every lane which lanes nearer the least significant end carry exactly the same value. The answer for lane j is a bitmap of j bits, placed in the low bits of lane j's own slot in the result. A scatter or histogram loop can use this bitmap to find the lanes that would collide on the same address.

The unit works on 128, 256 or 512 bits of the vector. A per-lane write mask chooses which lanes are computed. Each lane left out either keeps the old destination value (merge) or is cleared (zeroing). A broadcast mode copies one scalar into every lane before the comparison. The comparison network is combinational. One register stage then holds the result and raises a one-cycle valid pulse. A reserved operand field that is not all ones marks the operation illegal, and the stored result is then left alone.

Top module: `lane_conflict_unit`

## Requirements
- R1: For a computed lane j, result bit k (0 <= k < j) is 1 exactly when lane j equals lane k, so lane 0 always produces zero.
- R2: In a computed lane j, every result bit from position j up to the lane's top bit is 0.
- R3: The lane count is 4, 8 or 16 with `elem64`=0 and 2, 4 or 8 with `elem64`=1, for `vlen` codes 0, 1 and 2 (128, 256 and 512 bits).
- R4: With `mask_en`=0 every active lane is computed. With `mask_en`=1, lane j is computed only when `mask[j]` is 1, and mask bits at or above the active lane count have no effect.
- R5: A lane that is not computed takes the matching slice of `prev_dst` when `zero_mode`=0, and becomes all zeros when `zero_mode`=1.
- R6: Result bits at and above the selected vector length, up to bit 511, are 0 in both merge and zeroing modes.
- R7: With `bcast`=1, the low 32 bits (32-bit lanes) or the low 64 bits (64-bit lanes) of `scalar` fill every lane, so computed lane j gets ones in bits 0..j-1.
- R8: An operation is illegal when `resv` is not 4'b1111 or when `vlen` is 3. In the cycle after such a strobe, `illegal` is 1, `out_valid` is 0 and `dst` keeps its previous value.
- R9: `dst` and `out_valid`=1 appear in the cycle after a legal `in_valid` strobe. Without a strobe, `out_valid` and `illegal` are 0 in the following cycle.
- R10: A synchronous active-high reset clears `dst`, `out_valid` and `illegal`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| elem64 | input | 1 | 0: 32-bit lanes, 1: 64-bit lanes |
| vlen | input | 2 | 0: 128, 1: 256, 2: 512 bits, 3: illegal |
| mask_en | input | 1 | Enables the per-lane write mask |
| mask | input | 16 | Per-lane write mask, bit j for lane j |
| zero_mode | input | 1 | 0: merge unselected lanes, 1: clear them |
| bcast | input | 1 | Replicate `scalar` into every lane |
| resv | input | 4 | Reserved field, must be 4'b1111 |
| src | input | 512 | Source vector |
| scalar | input | 64 | Scalar used in broadcast mode |
| prev_dst | input | 512 | Old destination value used for merging |
| out_valid | output | 1 | One-cycle pulse when a legal result is stored |
| illegal | output | 1 | One-cycle pulse after an illegal strobe |
| dst | output | 512 | Registered result |

## Verification
The assertions assume that the control inputs sampled with `in_valid` are held until the clock edge that captures them. They also assume that `vlen` is still known one cycle later, when the upper-zero check reads it back through `$past`. The bench meets both conditions: it changes every input on the falling edge only and drops the strobe after one cycle. The random stimulus covers all three legal `vlen` codes, both lane sizes, both masking modes and broadcast. It builds lanes from a small pool of values, so the comparison network sees duplicates on most operations, and it feeds code 3 and bad reserved values only in the directed illegal cases.

// File: rtl/lcu_pkg.sv
package lcu_pkg;
    localparam int VEC_W    = 512;
    localparam int DW       = 32;
    localparam int QW       = 64;
    localparam int LANES_D  = VEC_W / DW;
    localparam int LANES_Q  = VEC_W / QW;
    localparam int SCALAR_W = QW;
    localparam logic [3:0] RESV_OK = 4'b1111;

    typedef enum logic [1:0] {
        VL_128 = 2'd0,
        VL_256 = 2'd1,
        VL_512 = 2'd2,
        VL_BAD = 2'd3
    } vlen_e;

    function automatic logic op_legal(logic [3:0] resv, logic [1:0] vl);
        return (resv == RESV_OK) && (vl != VL_BAD);
    endfunction

    // number of 32-bit chunks inside the selected length
    function automatic int active_chunks(logic [1:0] vl);
        return 4 << vl;
    endfunction
endpackage

// File: rtl/lcu_bcast.sv
module lcu_bcast
    import lcu_pkg::*;
#(
    parameter int W = VEC_W
) (
    input  logic                bcast,
    input  logic                elem64,
    input  logic [W-1:0]        src,
    input  logic [SCALAR_W-1:0] scalar,
    output logic [W-1:0]        vec
);
    localparam int REP_D = W / DW;
    localparam int REP_Q = W / QW;

    always_comb begin
        if (!bcast)
            vec = src;
        else if (elem64)
            vec = {REP_Q{scalar[QW-1:0]}};
        else
            vec = {REP_D{scalar[DW-1:0]}};
    end
endmodule

// File: rtl/lcu_cmp.sv
module lcu_cmp
    import lcu_pkg::*;
#(
    parameter int W  = VEC_W,
    parameter int EW = DW
) (
    input  logic         elem64,
    input  logic [W-1:0] vec,
    output logic [W-1:0] raw
);
    localparam int NL = W / EW;
    localparam int NQ = NL / 2;

    // pairwise equality of narrow lanes, only below the diagonal
    logic [NL-1:0] eq [NL];
    logic [W-1:0]  raw_d;
    logic [W-1:0]  raw_q;

    always_comb begin
        for (int j = 0; j < NL; j++)
            for (int k = 0; k < NL; k++)
                eq[j][k] = (k < j) && (vec[j*EW +: EW] == vec[k*EW +: EW]);
    end

    always_comb begin
        raw_d = '0;
        for (int j = 0; j < NL; j++)
            for (int k = 0; k < j; k++)
                raw_d[j*EW + k] = eq[j][k];
    end

    // a wide lane matches when both of its narrow halves match
    always_comb begin
        raw_q = '0;
        for (int q = 0; q < NQ; q++)
            for (int k = 0; k < q; k++)
                raw_q[q*2*EW + k] = eq[2*q][2*k] & eq[2*q+1][2*k+1];
    end

    assign raw = elem64 ? raw_q : raw_d;
endmodule

// File: rtl/lcu_pack.sv
module lcu_pack
    import lcu_pkg::*;
#(
    parameter int W  = VEC_W,
    parameter int EW = DW
) (
    input  logic               elem64,
    input  logic [1:0]         vlen,
    input  logic               mask_en,
    input  logic [W/EW-1:0]    mask,
    input  logic               zero_mode,
    input  logic [W-1:0]       raw,
    input  logic [W-1:0]       prev,
    output logic [W-1:0]       res
);
    localparam int NCH = W / EW;

    for (genvar c = 0; c < NCH; c++) begin : g_chunk
        localparam int LQ   = c / 2;
        localparam int D_LO = c;
        localparam int Q_LO = (c % 2 == 0) ? c / 2 : 0;
        logic in_rng;
        logic pick;

        always_comb begin
            in_rng = (c < active_chunks(vlen));
            pick   = !mask_en || (elem64 ? mask[LQ] : mask[c]);
        end

        assign res[c*EW +: EW] = !in_rng    ? '0 :
                                 pick       ? raw[c*EW +: EW] :
                                 zero_mode  ? '0 : prev[c*EW +: EW];

        // R2: the comparison network leaves the bits at and above the lane index clear
        always_comb begin
            if (!elem64)
                a_r2_high_clear_d: assert (raw[c*EW + D_LO +: (EW - D_LO)] == '0);
            else
                a_r2_high_clear_q: assert (raw[c*EW + Q_LO +: (EW - Q_LO)] == '0);
        end
    end

    // R1: lane 0 never reports a conflict
    always_comb begin
        a_r1_lane0_zero: assert (raw[EW-1:0] == '0);
    end
endmodule

// File: rtl/lane_conflict_unit.sv
module lane_conflict_unit
    import lcu_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic                elem64,
    input  logic [1:0]          vlen,
    input  logic                mask_en,
    input  logic [LANES_D-1:0]  mask,
    input  logic                zero_mode,
    input  logic                bcast,
    input  logic [3:0]          resv,
    input  logic [VEC_W-1:0]    src,
    input  logic [SCALAR_W-1:0] scalar,
    input  logic [VEC_W-1:0]    prev_dst,
    output logic                out_valid,
    output logic                illegal,
    output logic [VEC_W-1:0]    dst
);
    logic [VEC_W-1:0] vec;
    logic [VEC_W-1:0] raw;
    logic [VEC_W-1:0] res;
    logic             legal;

    assign legal = op_legal(resv, vlen);

    lcu_bcast #(.W(VEC_W)) u_bcast (
        .bcast(bcast), .elem64(elem64), .src(src), .scalar(scalar), .vec(vec)
    );

    lcu_cmp #(.W(VEC_W), .EW(DW)) u_cmp (
        .elem64(elem64), .vec(vec), .raw(raw)
    );

    lcu_pack #(.W(VEC_W), .EW(DW)) u_pack (
        .elem64(elem64), .vlen(vlen), .mask_en(mask_en), .mask(mask),
        .zero_mode(zero_mode), .raw(raw), .prev(prev_dst), .res(res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dst       <= '0;
            out_valid <= 1'b0;
            illegal   <= 1'b0;
        end else begin
            out_valid <= in_valid && legal;
            illegal   <= in_valid && !legal;
            if (in_valid && legal)
                dst <= res;
        end
    end

    // R9: a legal strobe yields a valid pulse next cycle
    a_r9_strobe_valid: assert property (@(posedge clk) disable iff (rst)
        in_valid && legal |=> out_valid && !illegal);

    // R9: no strobe, no pulses
    a_r9_quiet: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid && !illegal);

    // R8: illegal strobe flags and holds the result
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        in_valid && !legal |=> illegal && !out_valid && $stable(dst));

    // R6: nothing survives above the selected length
    a_r6_upper_128: assert property (@(posedge clk) disable iff (rst)
        out_valid && ($past(vlen) == 2'd0) |-> dst[VEC_W-1:128] == '0);
    a_r6_upper_256: assert property (@(posedge clk) disable iff (rst)
        out_valid && ($past(vlen) == 2'd1) |-> dst[VEC_W-1:256] == '0);

    // R10: reset clears the registered outputs
    a_r10_reset_clears: assert property (@(posedge clk)
        rst |=> dst == '0 && !out_valid && !illegal);
endmodule

// File: tb/sim_lane_conflict_unit.sv
module sim_lane_conflict_unit;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         elem64 = 1'b0;
    logic [1:0]   vlen = 2'd0;
    logic         mask_en = 1'b0;
    logic [15:0]  mask = '0;
    logic         zero_mode = 1'b0;
    logic         bcast = 1'b0;
    logic [3:0]   resv = 4'hF;
    logic [511:0] src = '0;
    logic [63:0]  scalar = '0;
    logic [511:0] prev_dst = '0;
    logic         out_valid;
    logic         illegal;
    logic [511:0] dst;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    lane_conflict_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .elem64(elem64), .vlen(vlen),
        .mask_en(mask_en), .mask(mask), .zero_mode(zero_mode), .bcast(bcast),
        .resv(resv), .src(src), .scalar(scalar), .prev_dst(prev_dst),
        .out_valid(out_valid), .illegal(illegal), .dst(dst)
    );

    function automatic logic [511:0] model(logic es, logic [1:0] vl, logic men,
            logic [15:0] m, logic zm, logic bc, logic [511:0] s_in,
            logic [63:0] sc, logic [511:0] pv);
        logic [511:0] s;
        logic [511:0] r;
        int ew;
        int nl;
        r  = '0;
        ew = es ? 64 : 32;
        nl = (128 << vl) / ew;
        if (bc) s = es ? {8{sc}} : {16{sc[31:0]}};
        else    s = s_in;
        for (int j = 0; j < nl; j++) begin
            if (!men || m[j]) begin
                for (int k = 0; k < j; k++) begin
                    bit same = 1;
                    for (int b = 0; b < ew; b++)
                        if (s[j*ew+b] != s[k*ew+b]) same = 0;
                    r[j*ew+k] = same;
                end
            end else if (!zm) begin
                for (int b = 0; b < ew; b++) r[j*ew+b] = pv[j*ew+b];
            end
        end
        return r;
    endfunction

    task automatic check_bit(string req, logic got, logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0b expected %0b", req, got, exp);
        end
    endtask

    task automatic check_vec(string req, logic [511:0] got, logic [511:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    // drive on falling edge, strobe one cycle, sample on the next falling edge
    task automatic run_op(string req);
        logic [511:0] exp;
        exp = model(elem64, vlen, mask_en, mask, zero_mode, bcast, src, scalar, prev_dst);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check_bit({req, " valid"}, out_valid, 1'b1);
        check_vec(req, dst, exp);
    endtask

    task automatic set_op(logic es, logic [1:0] vl, logic men, logic [15:0] m,
            logic zm, logic bc);
        elem64 = es; vlen = vl; mask_en = men; mask = m; zero_mode = zm; bcast = bc;
        resv = 4'hF;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog got timeout expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [511:0] held;
        logic [63:0]  pool [4];
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        check_vec("R10 reset dst", dst, '0);
        check_bit("R10 reset valid", out_valid, 1'b0);
        check_bit("R10 reset illegal", illegal, 1'b0);
        rst = 1'b0;
        @(negedge clk);

        // R1 R2: all lanes equal, 32-bit, full length
        set_op(1'b0, 2'd2, 1'b0, '0, 1'b0, 1'b0);
        src = {16{32'hA5A5_0001}};
        run_op("R1 all equal");
        check_vec("R2 lane15 pattern", {480'b0, dst[511:480]}, {497'b0, 15'h7FFF});

        // R1: all distinct
        for (int i = 0; i < 16; i++) src[i*32 +: 32] = 32'h100 + i;
        run_op("R1 distinct");
        check_vec("R1 distinct zero", dst, '0);

        // R3: 64-bit lanes at 256 with one duplicate pair
        set_op(1'b1, 2'd1, 1'b0, '0, 1'b0, 1'b0);
        src = '0;
        src[63:0] = 64'h1234_5678_9ABC_DEF0; src[127:64] = 64'h1;
        src[191:128] = 64'h1234_5678_9ABC_DEF0; src[255:192] = 64'h1234_5678_0000_0000;
        run_op("R3 q256");

        // R4: mask bits above lane count ignored
        set_op(1'b1, 2'd2, 1'b1, 16'hFF00, 1'b0, 1'b0);
        prev_dst = {512{1'b1}};
        run_op("R4 high mask ignored");
        check_vec("R4 all kept", dst, {512{1'b1}});

        // R5: zeroing of unselected lanes
        set_op(1'b0, 2'd2, 1'b1, 16'h00F0, 1'b1, 1'b0);
        src = {16{32'h7}};
        run_op("R5 zeroing");

        // R6: merge cannot leak above 128 bits
        set_op(1'b0, 2'd0, 1'b1, 16'h0005, 1'b0, 1'b0);
        run_op("R6 merge upper");
        check_vec("R6 upper zero", {128'b0, dst[511:128]}, '0);

        // R7: broadcast 64-bit
        set_op(1'b1, 2'd2, 1'b0, '0, 1'b0, 1'b1);
        scalar = 64'hDEAD_BEEF_0BAD_F00D;
        src = '0;
        run_op("R7 bcast q");

        // R8: illegal reserved field, then illegal length
        held = dst;
        set_op(1'b0, 2'd2, 1'b0, '0, 1'b0, 1'b0);
        resv = 4'b1110;
        src = {16{32'h9}};
        in_valid = 1'b1; @(negedge clk); in_valid = 1'b0;
        check_bit("R8 resv flag", illegal, 1'b1);
        check_bit("R8 resv no valid", out_valid, 1'b0);
        check_vec("R8 resv held", dst, held);
        resv = 4'hF; vlen = 2'd3;
        in_valid = 1'b1; @(negedge clk); in_valid = 1'b0;
        check_bit("R8 vlen flag", illegal, 1'b1);
        check_vec("R8 vlen held", dst, held);

        // R9: idle cycle gives no pulses and keeps the result
        @(negedge clk);
        check_bit("R9 idle valid", out_valid, 1'b0);
        check_bit("R9 idle illegal", illegal, 1'b0);
        check_vec("R9 idle held", dst, held);

        // random operations with forced duplicates
        for (int n = 0; n < 600; n++) begin
            string tag;
            for (int p = 0; p < 4; p++) pool[p] = {$urandom, $urandom};
            set_op($urandom % 2, $urandom % 3, $urandom % 2, $urandom,
                   $urandom % 2, ($urandom % 8) == 0);
            for (int q = 0; q < 8; q++) begin
                if ($urandom % 3 == 0) src[q*64 +: 64] = {$urandom, $urandom};
                else if (elem64)       src[q*64 +: 64] = pool[$urandom % 4];
                else src[q*64 +: 64] = {pool[$urandom % 4][31:0], pool[$urandom % 4][31:0]};
            end
            scalar   = pool[$urandom % 4];
            prev_dst = {16{$urandom}};
            tag = bcast ? "R7 random" : mask_en ? "R5 random" : "R3 random";
            run_op(tag);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule